// File: doc/BRIEF.md
# PWM Event Interrupt and Trigger Unit

This block turns the counter events of several PWM generators into sticky interrupt status, interrupt lines and single-cycle trigger pulses. Every generator delivers six event strobes per clock: the count reaching zero, the count reloading, and compare matches of channel A and channel B while counting up and while counting down. Each generator keeps a raw status vector that records which events have happened since the last clear. Two independent enable masks are applied to the same six events. One decides which recorded events reach the generator's interrupt line. The other decides which events emit a trigger pulse for downstream logic, such as a converter start.

A module-level layer combines the generator interrupt lines with one fault source into a small summary vector. It applies its own enable mask and drives a single interrupt output. Both layers clear their sticky bits with write-one-to-clear strobes. Register decoding is left to the surrounding bus logic: masks and clear strobes arrive as plain inputs.

Top module: `pwm_evt_top`

## Requirements
- R1: While reset is applied, and until the first event after it, every raw and masked status bit, every trigger bit, every generator interrupt line and the module interrupt read 0.
- R2: An event strobe at bit i of generator g (port bit g*6+i, with i = 0 count zero, 1 reload, 2 compare A up, 3 compare A down, 4 compare B up, 5 compare B down) sets raw status bit g*6+i at the next clock edge. The bit then stays set until it is cleared.
- R3: The generator masked status equals raw status ANDed with the generator interrupt enable mask, and the interrupt line of generator g is the OR of its six masked bits.
- R4: A 1 on a clear strobe bit clears that raw status bit at the next clock edge. A 0 on a clear strobe bit leaves that bit unchanged.
- R5: When an event and a clear of the same bit arrive in the same cycle, the bit is set after the edge.
- R6: A trigger bit is high for exactly the one cycle after a cycle in which its event strobe was high and its trigger enable was set. Triggers are not latched.
- R7: The interrupt enable mask and the trigger enable mask act independently. An event whose interrupt enable is 0 still sets raw status and can still trigger. An event whose trigger enable is 0 still sets raw status.
- R8: Module raw status bit g (g < number of generators) equals the interrupt line of generator g in the same cycle.
- R9: A fault strobe sets module raw status bit 3 (the bit just above the generator bits) at the next edge. A fault-clear strobe clears that bit, and a fault that arrives together with a clear wins.
- R10: The module masked status equals module raw status ANDed with the module enable mask, and the module interrupt is the OR of the module masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gen_evt_i | input | NUM_GEN*6 | Event strobes, six per generator |
| gen_ien_i | input | NUM_GEN*6 | Interrupt enable mask per event |
| gen_ten_i | input | NUM_GEN*6 | Trigger enable mask per event |
| gen_clr_i | input | NUM_GEN*6 | Write-one-to-clear strobes for raw status |
| fault_i | input | 1 | Fault event strobe |
| fault_clr_i | input | 1 | Write-one-to-clear strobe for the fault status bit |
| mod_ien_i | input | NUM_GEN+1 | Module enable mask, generators low, fault on top |
| gen_raw_o | output | NUM_GEN*6 | Raw generator status |
| gen_masked_o | output | NUM_GEN*6 | Masked generator status |
| gen_trig_o | output | NUM_GEN*6 | Single-cycle trigger pulses |
| gen_irq_o | output | NUM_GEN | Interrupt line per generator |
| mod_raw_o | output | NUM_GEN+1 | Raw module status |
| mod_masked_o | output | NUM_GEN+1 | Masked module status |
| mod_irq_o | output | 1 | Combined module interrupt |

## Verification
The bench builds the block with three generators, the default. This gives 18 event bits and puts the fault bit at module position 3. Every event slot is hit on its own, so a swapped or miswired bit shows up in one generator while the other two stay quiet. With three generators, enable patterns can also leave one generator line active while the others are masked, which checks the module summary bit by bit. A long random phase then mixes events, clears, masks and faults at the same time, so collisions of event and clear on the same bit are exercised many times.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  // events per generator: 0 zero, 1 reload, 2 A up, 3 A down, 4 B up, 5 B down
  localparam int unsigned EVT_CNT = 6;
  typedef logic [EVT_CNT-1:0] evt_vec_t;
endpackage

// File: rtl/pwm_evt_rst_sync.sv
module pwm_evt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_evt_gen_stat.sv
module pwm_evt_gen_stat
  import pwm_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  evt_vec_t evt_i,
  input  evt_vec_t ien_i,
  input  evt_vec_t ten_i,
  input  evt_vec_t clr_i,
  output evt_vec_t raw_o,
  output evt_vec_t masked_o,
  output evt_vec_t trig_o,
  output logic     irq_o
);
  evt_vec_t raw_q, raw_d;
  evt_vec_t trig_q, trig_d;
  logic     raw_en;

  // event has priority over a simultaneous clear
  always_comb begin
    raw_en = |(evt_i | clr_i);
    raw_d  = (raw_q & ~clr_i) | evt_i;
    trig_d = evt_i & ten_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      trig_q <= '0;
    end else begin
      if (raw_en) begin
        raw_q <= raw_d;
      end
      trig_q <= trig_d;
    end
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & ien_i;
  assign irq_o    = |(raw_q & ien_i);
  assign trig_o   = trig_q;
endmodule

// File: rtl/pwm_evt_mod_stat.sv
module pwm_evt_mod_stat #(
  parameter int unsigned NUM_GEN  = 3,
  localparam int unsigned MOD_BITS = NUM_GEN + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_GEN-1:0]  gen_irq_i,
  input  logic                fault_i,
  input  logic                fault_clr_i,
  input  logic [MOD_BITS-1:0] ien_i,
  output logic [MOD_BITS-1:0] raw_o,
  output logic [MOD_BITS-1:0] masked_o,
  output logic                irq_o
);
  logic flt_q, flt_d, flt_en;

  always_comb begin
    flt_en = fault_i | fault_clr_i;
    flt_d  = fault_i | (flt_q & ~fault_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= 1'b0;
    end else if (flt_en) begin
      flt_q <= flt_d;
    end
  end

  assign raw_o    = {flt_q, gen_irq_i};
  assign masked_o = {flt_q, gen_irq_i} & ien_i;
  assign irq_o    = |({flt_q, gen_irq_i} & ien_i);
endmodule

// File: rtl/pwm_evt_top.sv
module pwm_evt_top
  import pwm_evt_pkg::*;
#(
  parameter int unsigned NUM_GEN  = 3,
  localparam int unsigned GEN_BITS = NUM_GEN * EVT_CNT,
  localparam int unsigned MOD_BITS = NUM_GEN + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [GEN_BITS-1:0] gen_evt_i,
  input  logic [GEN_BITS-1:0] gen_ien_i,
  input  logic [GEN_BITS-1:0] gen_ten_i,
  input  logic [GEN_BITS-1:0] gen_clr_i,
  input  logic                fault_i,
  input  logic                fault_clr_i,
  input  logic [MOD_BITS-1:0] mod_ien_i,
  output logic [GEN_BITS-1:0] gen_raw_o,
  output logic [GEN_BITS-1:0] gen_masked_o,
  output logic [GEN_BITS-1:0] gen_trig_o,
  output logic [NUM_GEN-1:0]  gen_irq_o,
  output logic [MOD_BITS-1:0] mod_raw_o,
  output logic [MOD_BITS-1:0] mod_masked_o,
  output logic                mod_irq_o
);
  logic rst_n_s;

  pwm_evt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    pwm_evt_gen_stat u_gen (
      .clk_i    (clk_i),
      .rst_ni   (rst_n_s),
      .evt_i    (gen_evt_i[g*EVT_CNT +: EVT_CNT]),
      .ien_i    (gen_ien_i[g*EVT_CNT +: EVT_CNT]),
      .ten_i    (gen_ten_i[g*EVT_CNT +: EVT_CNT]),
      .clr_i    (gen_clr_i[g*EVT_CNT +: EVT_CNT]),
      .raw_o    (gen_raw_o[g*EVT_CNT +: EVT_CNT]),
      .masked_o (gen_masked_o[g*EVT_CNT +: EVT_CNT]),
      .trig_o   (gen_trig_o[g*EVT_CNT +: EVT_CNT]),
      .irq_o    (gen_irq_o[g])
    );
  end

  pwm_evt_mod_stat #(.NUM_GEN(NUM_GEN)) u_mod (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .gen_irq_i   (gen_irq_o),
    .fault_i     (fault_i),
    .fault_clr_i (fault_clr_i),
    .ien_i       (mod_ien_i),
    .raw_o       (mod_raw_o),
    .masked_o    (mod_masked_o),
    .irq_o       (mod_irq_o)
  );
endmodule

// File: rtl/pwm_evt_chk.sv
module pwm_evt_chk #(
  parameter int unsigned NUM_GEN  = 3,
  parameter int unsigned GEN_BITS = 18
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [GEN_BITS-1:0] gen_evt_i,
  input logic [GEN_BITS-1:0] gen_clr_i,
  input logic [GEN_BITS-1:0] gen_ten_i,
  input logic [GEN_BITS-1:0] gen_raw_o,
  input logic [GEN_BITS-1:0] gen_trig_o,
  input logic                fault_i,
  input logic                fault_clr_i,
  input logic [NUM_GEN:0]    mod_raw_o
);
  assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_evt_i != '0) |=> ((gen_raw_o & $past(gen_evt_i)) == $past(gen_evt_i)));

  assert_status_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_raw_o != '0) |=> (((gen_raw_o ^ $past(gen_raw_o)) & ~$past(gen_evt_i | gen_clr_i)) == '0));

  assert_w1c_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gen_clr_i & ~gen_evt_i) != '0) |=> ((gen_raw_o & $past(gen_clr_i & ~gen_evt_i)) == '0));

  assert_trig_needs_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((gen_trig_o & ~($past(gen_evt_i) & $past(gen_ten_i))) == '0));

  assert_fault_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> mod_raw_o[NUM_GEN]);

  assert_fault_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_raw_o[NUM_GEN] && !fault_clr_i) |=> mod_raw_o[NUM_GEN]);
endmodule

bind pwm_evt_top pwm_evt_chk #(.NUM_GEN(NUM_GEN), .GEN_BITS(GEN_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_n_s),
  .gen_evt_i   (gen_evt_i),
  .gen_clr_i   (gen_clr_i),
  .gen_ten_i   (gen_ten_i),
  .gen_raw_o   (gen_raw_o),
  .gen_trig_o  (gen_trig_o),
  .fault_i     (fault_i),
  .fault_clr_i (fault_clr_i),
  .mod_raw_o   (mod_raw_o)
);

// File: tb/pwm_evt_top_bench.sv
module pwm_evt_top_bench;
  localparam int NG = 3;
  localparam int NE = 6;
  localparam int GB = NG * NE;
  localparam int MB = NG + 1;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [GB-1:0] evt, ien, ten, clr;
  logic          flt, fclr;
  logic [MB-1:0] mien;
  logic [GB-1:0] raw, msk, trg;
  logic [NG-1:0] girq;
  logic [MB-1:0] mraw, mmsk;
  logic          mirq;

  pwm_evt_top #(.NUM_GEN(NG)) u_pwm_evt_top (
    .clk_i(clk), .rst_ni(rst_n),
    .gen_evt_i(evt), .gen_ien_i(ien), .gen_ten_i(ten), .gen_clr_i(clr),
    .fault_i(flt), .fault_clr_i(fclr), .mod_ien_i(mien),
    .gen_raw_o(raw), .gen_masked_o(msk), .gen_trig_o(trg), .gen_irq_o(girq),
    .mod_raw_o(mraw), .mod_masked_o(mmsk), .mod_irq_o(mirq)
  );

  // behavioural reference state
  bit [GB-1:0] m_raw, m_trg;
  bit          m_flt;
  int          checks = 0;
  int          fails = 0;
  string       req = "R1";

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit [GB-1:0] e_msk;
    bit [MB-1:0] e_mraw, e_mmsk;
    e_msk = m_raw & ien;
    for (int g = 0; g < NG; g++) e_mraw[g] = |e_msk[g*NE +: NE];
    e_mraw[NG] = m_flt;
    e_mmsk = e_mraw & mien;
    chk("raw status", 32'(raw), 32'(m_raw));
    chk("masked status", 32'(msk), 32'(e_msk));
    chk("trigger", 32'(trg), 32'(m_trg));
    chk("gen irq", 32'(girq), 32'(e_mraw[NG-1:0]));
    chk("module raw", 32'(mraw), 32'(e_mraw));
    chk("module masked", 32'(mmsk), 32'(e_mmsk));
    chk("module irq", 32'(mirq), 32'(|e_mmsk));
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw = '0;
      m_trg = '0;
      m_flt = 1'b0;
    end else begin
      for (int i = 0; i < GB; i++) begin
        if (evt[i]) m_raw[i] = 1'b1;
        else if (clr[i]) m_raw[i] = 1'b0;
        m_trg[i] = evt[i] & ten[i];
      end
      if (flt) m_flt = 1'b1;
      else if (fclr) m_flt = 1'b0;
    end
    #5 compare();
  end

  task automatic step(logic [GB-1:0] e, logic [GB-1:0] c, logic f, logic fc);
    @(negedge clk);
    evt = e; clr = c; flt = f; fclr = fc;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step('0, '0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    evt = '0; clr = '0; ien = '0; ten = '0; flt = 1'b0; fclr = 1'b0; mien = '0;
    req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    req = "R2";
    for (int i = 0; i < GB; i++) begin
      step(GB'(1) << i, '0, 1'b0, 1'b0);
      idle(1);
    end
    idle(2);

    req = "R3";
    ien = 18'h2A5C3; idle(2);
    ien = 18'h0003F; idle(2);
    ien = '1;        idle(2);

    req = "R4";
    step('0, 18'h0F0F0, 1'b0, 1'b0); idle(2);
    step('0, '0, 1'b0, 1'b0);        idle(2);
    step('0, '1, 1'b0, 1'b0);        idle(2);

    req = "R5";
    step(18'h15555, 18'h3FFFF, 1'b0, 1'b0); idle(1);
    step(18'h00FF0, 18'h0FF00, 1'b0, 1'b0); idle(2);

    req = "R6";
    ten = 18'h3F03F;
    step(18'h00001, '0, 1'b0, 1'b0);
    step(18'h00001, '0, 1'b0, 1'b0);
    step(18'h10040, '0, 1'b0, 1'b0);
    idle(3);

    req = "R7";
    step('0, '1, 1'b0, 1'b0);
    ien = '0; ten = '1;
    step(18'h2AAAA, '0, 1'b0, 1'b0); idle(2);
    ten = '0;
    step(18'h15555, '0, 1'b0, 1'b0); idle(2);

    req = "R8";
    mien = '1;
    ien = 18'h00FC0; idle(2);
    ien = 18'h3F000; idle(2);
    step('0, '1, 1'b0, 1'b0); idle(1);
    step(18'h00080, '0, 1'b0, 1'b0); idle(2);

    req = "R9";
    step('0, '0, 1'b1, 1'b0); idle(2);
    step('0, '0, 1'b0, 1'b1); idle(2);
    step('0, '0, 1'b1, 1'b1); idle(2);
    step('0, '0, 1'b0, 1'b1); idle(1);
    step('0, '0, 1'b0, 1'b1); idle(1);

    req = "R10";
    step(18'h3FFFF, '0, 1'b1, 1'b0);
    ien = '1;
    for (int m = 0; m < (1 << MB); m++) begin
      mien = MB'(m);
      idle(1);
    end

    req = "R2";
    for (int k = 0; k < 400; k++) begin
      ien  = GB'($urandom);
      ten  = GB'($urandom);
      mien = MB'($urandom);
      step(GB'($urandom & $urandom), GB'($urandom & $urandom),
           1'(($urandom % 8) == 0), 1'(($urandom % 4) == 0));
    end
    idle(3);
    finish_run();
  end
endmodule